// File: doc/BRIEF.md
# One-Time-Writable Byte Array with Pulse-Qualified Programming

This block is a clocked, synthesizable model of a window-erasable read-only byte array, 2**ADDR_W words of DATA_W bits (2048 x 8 by default). Two control levels, a chip-select level `ce` and an output-gate level `oe`, are decoded together with a programming-supply-present flag `vpp_hi` into six operating modes. With the supply absent the array is read, output-gated or parked in standby. With the supply present the same `ce` input changes role: it becomes an active-high program pulse while `oe` is high. With `ce` low it becomes verify or program inhibit, depending on `oe`.

A write is only accepted when the `ce` pulse lasts between PW_MIN and PW_MAX clock cycles. The write happens at the pulse's falling edge and can only clear bits: the stored word becomes the old word AND the presented data. Only the `erase` input brings bits back to one, and it does so for every word at once. A pulse that is too short, too long or broken off by a supply or `oe` change writes nothing. It sets a sticky error flag instead.

The tri-state data port is modelled as a split pair: an input bus `dq_in`, an output bus `dq_out` and a drive-enable `dq_drive`. The output bus reads zero whenever it is not driven.

Top module: `eprom_array_model`

## Requirements
- R1: Every word is separately addressable, in any order. Programming one address leaves every other address unchanged.
- R2: `erase` high at a rising clock edge sets every word to all ones. When a write commits at the same edge, erase takes priority.
- R3: With `vpp_hi`=0, `ce`=0 and `oe`=0 the mode is read. `mode_o`=0, `dq_drive`=1 and `dq_out` equals the word at `addr`.
- R4: With `vpp_hi`=0 and `ce`=1 the mode is standby (`mode_o`=2), whatever `oe` is. With `vpp_hi`=0, `ce`=0 and `oe`=1 the mode is output disable (`mode_o`=1). `dq_drive`=0 in both cases.
- R5: With `vpp_hi`=1 and `oe`=1, `ce`=1 is program (`mode_o`=3, `dq_drive`=0). Suppose `ce` is sampled high at W consecutive rising edges, with PW_MIN <= W <= PW_MAX. At the next edge, if `ce` is sampled low while `vpp_hi` and `oe` are still high, the word at `addr` becomes old AND `dq_in`.
- R6: A write never turns a 0 bit into a 1. One bits in `dq_in` leave the stored bit unchanged.
- R7: With `vpp_hi`=1 and `ce`=0, `oe`=0 is verify (`mode_o`=4, driven with the stored word) and `oe`=1 is program inhibit (`mode_o`=5, `dq_drive`=0). With `vpp_hi`=1, `ce`=1 and `oe`=0 the mode is standby (`mode_o`=2).
- R8: A pulse shorter than PW_MIN cycles writes nothing and sets `pulse_err`.
- R9: A pulse still high after PW_MAX cycles sets `pulse_err` at its (PW_MAX+1)-th high edge, while `ce` is still held. It writes nothing when it ends.
- R10: A pulse that ends because `vpp_hi` or `oe` dropped writes nothing and sets `pulse_err`.
- R11: `pulse_err` is 0 after reset. Once set, it stays set until the next reset. Later valid pulses still write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (control state only; array contents persist) |
| erase | input | 1 | Set all words to all ones |
| vpp_hi | input | 1 | Programming supply present |
| ce | input | 1 | Chip-select level; program pulse when supply present |
| oe | input | 1 | Output-gate level |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data presented for programming |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_drive | output | 1 | Data port drive enable |
| mode_o | output | 3 | Decoded operating mode (encoding in R3, R4, R5, R7) |
| pulse_err | output | 1 | Sticky bad-pulse flag |

## Verification
The bench keeps the default 2048 x 8 array but shrinks the pulse window to PW_MIN=3 and PW_MAX=5 cycles. That makes widths on both sides of each limit cheap to reach: one cycle short, exactly at each limit, and one cycle over, where the error must appear while `ce` is still high. With a short window, many pulses fit in a short run. Repeated writes to the same address can therefore show the AND-only accumulation and the erase-versus-commit collision.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_OUTOFF  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5
    } op_mode_t;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic     ce,
    input  logic     oe,
    input  logic     vpp_hi,
    output op_mode_t mode,
    output logic     drive
);

    always_comb begin
        if (!vpp_hi) begin
            if (ce)      mode = MODE_STANDBY;
            else if (oe) mode = MODE_OUTOFF;
            else         mode = MODE_READ;
        end else begin
            if (ce && oe)  mode = MODE_PROGRAM;
            else if (ce)   mode = MODE_STANDBY;
            else if (oe)   mode = MODE_INHIBIT;
            else           mode = MODE_VERIFY;
        end
    end

    assign drive = (mode == MODE_READ) || (mode == MODE_VERIFY);

endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
    parameter int PW_MIN = 45,
    parameter int PW_MAX = 55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic oe,
    input  logic vpp_hi,
    output logic wr_en,
    output logic pulse_err
);

    localparam int CNT_W = $clog2(PW_MAX + 2);
    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(PW_MIN);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(PW_MAX);
    localparam logic [CNT_W-1:0] OVER_C = CNT_W'(PW_MAX + 1);

    typedef struct packed {
        logic             in_pulse;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } timer_st_t;

    timer_st_t st_d, st_q;

    logic prog_lvl;
    logic clean_end;
    logic in_win;

    assign prog_lvl  = vpp_hi && oe && ce;
    assign clean_end = vpp_hi && oe && !ce;
    assign in_win    = (st_q.cnt >= MIN_C) && (st_q.cnt <= MAX_C);

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (!st_q.in_pulse) begin
            if (prog_lvl) begin
                st_d.in_pulse = 1'b1;
                st_d.cnt      = CNT_W'(1);
            end
        end else if (prog_lvl) begin
            if (st_q.cnt != OVER_C) st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == MAX_C)  st_d.err = 1'b1;
        end else begin
            st_d.in_pulse = 1'b0;
            st_d.cnt      = '0;
            if (clean_end && in_win) wr_en    = 1'b1;
            else                     st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_err = st_q.err;

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err |=> pulse_err);

    p_write_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!ce && $past(ce)));

    p_err_from_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_err) |-> $past(st_q.in_pulse));

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] word_d;

    assign cur_word = mem_q[addr];
    assign rdata    = cur_word;

    always_comb begin
        word_d = cur_word & wdata;
    end

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[addr] <= word_d;
        end
    end

    p_and_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> (mem_q[$past(addr)] == ($past(cur_word) & $past(wdata))));

    p_erase_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem_q[$past(addr)] == '1));

endmodule

// File: rtl/eprom_array_model.sv
module eprom_array_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int PW_MIN = 45,
    parameter int PW_MAX = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              vpp_hi,
    input  logic              ce,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic [2:0]        mode_o,
    output logic              pulse_err
);

    op_mode_t          mode;
    logic              drive;
    logic              wr_en;
    logic [DATA_W-1:0] rdata;

    eprom_mode_dec u_dec (
        .ce     (ce),
        .oe     (oe),
        .vpp_hi (vpp_hi),
        .mode   (mode),
        .drive  (drive)
    );

    eprom_pulse_timer #(
        .PW_MIN (PW_MIN),
        .PW_MAX (PW_MAX)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .oe        (oe),
        .vpp_hi    (vpp_hi),
        .wr_en     (wr_en),
        .pulse_err (pulse_err)
    );

    eprom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (dq_in),
        .rdata (rdata)
    );

    assign dq_drive = drive;
    assign dq_out   = drive ? rdata : '0;
    assign mode_o   = mode;

    p_standby_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && ce) |-> !dq_drive);

    p_drive_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (!ce && !oe));

    p_program_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && ce && oe) |-> (!dq_drive && mode_o == 3'd3));

endmodule

// File: tb/eprom_array_model_test.sv
`timescale 1ns/1ps
module eprom_array_model_test;

    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int PMN = 3;
    localparam int PMX = 5;
    localparam int NT  = 8;

    localparam logic [AW-1:0] T_ADDR [NT] = '{11'h000, 11'h3C1, 11'h000, 11'h155,
                                              11'h2AA, 11'h3C1, 11'h001, 11'h000};
    localparam logic [DW-1:0] T_DATA [NT] = '{8'hA5, 8'h0F, 8'hF0, 8'hFF,
                                              8'h00, 8'hFF, 8'h7E, 8'h5F};
    localparam int            T_W    [NT] = '{3, 5, 4, 4, 3, 3, 5, 4};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase = 1'b0;
    logic          vpp_hi = 1'b0;
    logic          ce = 1'b1;
    logic          oe = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drive;
    logic [2:0]    mode_o;
    logic          pulse_err;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [1 << AW];

    always #2 clk = ~clk;

    eprom_array_model #(
        .ADDR_W (AW), .DATA_W (DW), .PW_MIN (PMN), .PW_MAX (PMX)
    ) uut (
        .clk (clk), .rst_n (rst_n), .erase (erase), .vpp_hi (vpp_hi),
        .ce (ce), .oe (oe), .addr (addr), .dq_in (dq_in),
        .dq_out (dq_out), .dq_drive (dq_drive), .mode_o (mode_o),
        .pulse_err (pulse_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_erase();
        erase = 1'b1;
        tick();
        erase = 1'b0;
        for (int i = 0; i < (1 << AW); i++) shadow[i] = '1;
    endtask

    task automatic do_pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input int w);
        vpp_hi = 1'b1; oe = 1'b1; ce = 1'b0; addr = a; dq_in = d;
        tick();
        ce = 1'b1;
        repeat (w) tick();
        ce = 1'b0;
        tick();
    endtask

    task automatic verify(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        vpp_hi = 1'b1; ce = 1'b0; oe = 1'b0; addr = a;
        #1;
        chk({tag, " verify mode"}, 32'(mode_o), 32'd4);
        chk({tag, " verify data"}, {23'd0, dq_drive, dq_out}, {23'd0, 1'b1, exp});
    endtask

    task automatic nread(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        vpp_hi = 1'b0; ce = 1'b0; oe = 1'b0; addr = a;
        #1;
        chk({tag, " read mode"}, 32'(mode_o), 32'd0);
        chk({tag, " read data"}, {23'd0, dq_drive, dq_out}, {23'd0, 1'b1, exp});
    endtask

    task automatic mode_chk(input string tag, input logic v, input logic c, input logic o,
                            input logic [2:0] em);
        vpp_hi = v; ce = c; oe = o;
        #1;
        chk({tag, " mode"}, 32'(mode_o), 32'(em));
        chk({tag, " hi-z"}, {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic do_reset();
        vpp_hi = 1'b0; ce = 1'b1; oe = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R11: reset state
        chk("R11 reset err", 32'(pulse_err), 32'd0);
        // R4: standby regardless of oe
        mode_chk("R4 standby oe1", 1'b0, 1'b1, 1'b1, 3'd2);
        mode_chk("R4 standby oe0", 1'b0, 1'b1, 1'b0, 3'd2);
        mode_chk("R4 outoff", 1'b0, 1'b0, 1'b1, 3'd1);
        // R7: supply-high modes without a pulse
        mode_chk("R7 inhibit", 1'b1, 1'b0, 1'b1, 3'd5);
        mode_chk("R7 standby vpp", 1'b1, 1'b1, 1'b0, 3'd2);
        vpp_hi = 1'b0; ce = 1'b1; oe = 1'b1;
        tick();

        // R2: erase gives all ones
        do_erase();
        nread("R2 R3 erased 000", 11'h000, 8'hFF);
        nread("R2 R3 erased 7FF", 11'h7FF, 8'hFF);

        // R5 R6 R1: table of valid pulses
        for (int k = 0; k < NT; k++) begin
            do_pulse(T_ADDR[k], T_DATA[k], T_W[k]);
            shadow[T_ADDR[k]] = shadow[T_ADDR[k]] & T_DATA[k];
            verify($sformatf("R5 R6 vec%0d", k), T_ADDR[k], shadow[T_ADDR[k]]);
        end
        chk("R5 no err on valid widths", 32'(pulse_err), 32'd0);
        // R1: every touched address plus an untouched one, in normal read
        for (int k = 0; k < NT; k++)
            nread($sformatf("R1 R3 readback%0d", k), T_ADDR[k], shadow[T_ADDR[k]]);
        nread("R1 untouched", 11'h7FF, 8'hFF);
        // R6: ones cannot be restored
        nread("R6 and-only 3C1", 11'h3C1, 8'h0F);

        // R5: program mode drives nothing while pulse level held
        vpp_hi = 1'b1; oe = 1'b1; ce = 1'b1;
        #1;
        chk("R5 program mode", 32'(mode_o), 32'd3);
        chk("R5 program hi-z", 32'(dq_drive), 32'd0);
        ce = 1'b0;
        tick();
        do_reset();

        // R8: short pulse
        do_pulse(11'h100, 8'h00, PMN - 1);
        chk("R8 short err", 32'(pulse_err), 32'd1);
        verify("R8 short no write", 11'h100, 8'hFF);
        // R11: sticky, and a valid pulse still writes
        do_pulse(11'h101, 8'h3C, PMN);
        chk("R11 err sticky", 32'(pulse_err), 32'd1);
        verify("R11 write after err", 11'h101, 8'h3C);
        do_reset();
        chk("R11 reset clears err", 32'(pulse_err), 32'd0);

        // R9: long pulse flags while ce still high
        vpp_hi = 1'b1; oe = 1'b1; ce = 1'b0; addr = 11'h200; dq_in = 8'h00;
        tick();
        ce = 1'b1;
        repeat (PMX) tick();
        chk("R9 no err at max", 32'(pulse_err), 32'd0);
        tick();
        chk("R9 err over max", 32'(pulse_err), 32'd1);
        repeat (3) tick();
        ce = 1'b0;
        tick();
        verify("R9 long no write", 11'h200, 8'hFF);
        do_reset();

        // R10: pulse broken by oe dropping
        vpp_hi = 1'b1; oe = 1'b1; ce = 1'b0; addr = 11'h300; dq_in = 8'h00;
        tick();
        ce = 1'b1;
        repeat (PMN + 1) tick();
        oe = 1'b0;
        tick();
        ce = 1'b0;
        tick();
        chk("R10 abort err", 32'(pulse_err), 32'd1);
        verify("R10 abort no write", 11'h300, 8'hFF);
        do_reset();

        // R2: erase wins over a write committing at the same edge
        vpp_hi = 1'b1; oe = 1'b1; ce = 1'b0; addr = 11'h000; dq_in = 8'h00;
        tick();
        ce = 1'b1;
        repeat (PMN + 1) tick();
        ce = 1'b0;
        erase = 1'b1;
        tick();
        erase = 1'b0;
        verify("R2 erase priority", 11'h000, 8'hFF);
        nread("R2 erase all 3C1", 11'h3C1, 8'hFF);

        finish_run();
    end

endmodule